// File: doc/BRIEF.md
# Two-Line Fully Associative Byte Cache

This block is a very small data cache placed between a single-issue processor port and a byte-wide backing store. Each processor request is a load or a store of one byte at a 4-bit byte address. The cache keeps two lines of two bytes each. Either line may hold any block. On a miss it evicts the invalid line or, if both lines are valid, the least recently used one. Stores that miss allocate the block first.

A build-time parameter selects the write policy. With write-through, every store also sends its byte to memory. With write-back, each line carries a dirty flag, and a dirty victim is copied out before the new block is fetched. A flush input writes out the dirty lines and then empties the cache. Two running counters record hits and misses, so a known access trace can be scored at the ports.

The processor side uses a ready/valid request and a one-cycle response pulse. The memory side holds one byte request until the memory acknowledges it.

Top module: `assoc2_cache`

## Requirements
- R1: An address splits into a 1-bit byte offset (bit 0) and a 3-bit block tag (bits 3:1). A load returns the byte most recently stored at that address, or the memory byte if there was no such store.
- R2: A request is taken at a rising edge where req_valid and req_ready are both high. req_ready is low while a miss, a memory write or a flush is in progress, and it is low in any cycle where flush is high.
- R3: A load hit raises resp_valid with resp_hit=1 and the data in the cycle after acceptance, and it makes no memory transfer.
- R4: A miss reads both bytes of the block, offset 0 first and then offset 1, before it responds with resp_hit=0.
- R5: On a miss, an invalid line is filled first. Otherwise the least recently used line is replaced. Hits and fills both mark their line as most recently used.
- R6: A store miss brings the whole block into the cache and then updates the stored byte, so the other byte of the block hits afterwards.
- R7: With write-through (WRITE_BACK=0), every store writes exactly its one byte to memory, whether it hits or misses, and evictions write nothing.
- R8: With write-back (WRITE_BACK=1), a store sets the dirty flag of its line and writes nothing to memory. A dirty victim writes both bytes back before the fetch, and a clean victim is dropped without a write.
- R9: A flush pulse, taken while idle, writes back every valid dirty line (write-back only) and then invalidates both lines, so the next access misses.
- R10: hit_count and miss_count each rise by one for every accepted hit or miss. For the trace load 1, load 7, store 0, store 5, load 10, the counts end at 1 hit and 4 misses with 8 bytes read, and memory writes total 2 bytes with write-through or 4 bytes with write-back after a final flush.
- R11: After reset, both lines are invalid and clean, the recency state and both counters are zero, req_ready is high, and neither resp_valid nor mem_req is high.
- R12: While mem_req is high and mem_ack is low, mem_req, mem_we, mem_addr and mem_wdata stay unchanged into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | Processor request present |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Store data |
| req_ready | output | 1 | Cache can accept a request this cycle |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_hit | output | 1 | Access hit in the cache |
| resp_rdata | output | DATA_W | Load data, or the stored byte for a store |
| flush | input | 1 | Write back dirty lines and invalidate all lines |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | Memory completed the current transfer |
| mem_rdata | input | DATA_W | Memory read data, valid with mem_ack |
| hit_count | output | CNT_W | Accepted hits since reset |
| miss_count | output | CNT_W | Accepted misses since reset |

## Verification
A corrupted tag or valid flag shows up at the next access to that block, as a wrong resp_hit, a wrong response latency or an unexpected memory read. A wrong recency bit stays hidden until the next replacement with both lines valid. It then shows as a hit where a miss was expected, or the reverse, on a later access to the line that should have survived. A wrong dirty flag shows only when that line is evicted or flushed, as a write count that differs from the expected one and as a memory image that does not match a reference model.

// File: rtl/assoc2_cache_pkg.sv
package assoc2_cache_pkg;
  localparam int LINES     = 2;
  localparam int BLK_BYTES = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EVICT,
    ST_FILL,
    ST_APPLY,
    ST_WTHRU,
    ST_FLUSH
  } st_e;
endpackage

// File: rtl/assoc2_lookup.sv
module assoc2_lookup #(
  parameter int TAG_W = 3,
  parameter int LINES = 2,
  parameter int WAY_W = 1
) (
  input  logic [LINES-1:0]             valid,
  input  logic [LINES-1:0][TAG_W-1:0]  tags,
  input  logic [TAG_W-1:0]             probe,
  input  logic [WAY_W-1:0]             lru_way,
  output logic                         hit,
  output logic [WAY_W-1:0]             hit_way,
  output logic [WAY_W-1:0]             victim_way
);
  logic [LINES-1:0] match;

  for (genvar g = 0; g < LINES; g++) begin : g_cmp
    assign match[g] = valid[g] && (tags[g] == probe);
  end

  assign hit = |match;

  always_comb begin
    hit_way = '0;
    for (int i = 0; i < LINES; i++) begin
      if (match[i]) hit_way = WAY_W'(i);
    end
  end

  // lowest-numbered invalid line wins, else the recency choice
  always_comb begin
    victim_way = lru_way;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (!valid[i]) victim_way = WAY_W'(i);
    end
  end
endmodule

// File: rtl/assoc2_lru.sv
module assoc2_lru #(
  parameter int WAY_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch,
  input  logic [WAY_W-1:0] touch_way,
  output logic [WAY_W-1:0] lru_way
);
  logic [WAY_W-1:0] lru_q, lru_d;

  // with two lines the other line becomes least recent
  always_comb begin
    lru_d = lru_q;
    if (touch) lru_d = ~touch_way;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lru_q <= '0;
    else        lru_q <= lru_d;
  end

  assign lru_way = lru_q;
endmodule

// File: rtl/assoc2_counters.sv
module assoc2_counters #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_hit,
  input  logic             inc_miss,
  output logic [CNT_W-1:0] hit_count,
  output logic [CNT_W-1:0] miss_count
);
  logic [CNT_W-1:0] hit_q, miss_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q  <= '0;
      miss_q <= '0;
    end else begin
      if (inc_hit)  hit_q  <= hit_q + 1'b1;
      if (inc_miss) miss_q <= miss_q + 1'b1;
    end
  end

  assign hit_count  = hit_q;
  assign miss_count = miss_q;
endmodule

// File: rtl/assoc2_cache.sv
module assoc2_cache #(
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 8,
  parameter int CNT_W      = 8,
  parameter bit WRITE_BACK = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic [DATA_W-1:0] resp_rdata,
  input  logic              flush,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  miss_count
);
  import assoc2_cache_pkg::*;

  localparam int WAY_W = (LINES > 1) ? $clog2(LINES) : 1;
  localparam int OFF_W = (BLK_BYTES > 1) ? $clog2(BLK_BYTES) : 1;
  localparam int TAG_W = ADDR_W - OFF_W;
  localparam logic [OFF_W-1:0] LAST_BEAT = OFF_W'(BLK_BYTES - 1);
  localparam logic [WAY_W-1:0] LAST_WAY  = WAY_W'(LINES - 1);

  // line storage
  logic [LINES-1:0]                            valid_q, dirty_q;
  logic [LINES-1:0][TAG_W-1:0]                 tag_q;
  logic [LINES-1:0][BLK_BYTES-1:0][DATA_W-1:0] data_q;

  // control state
  st_e               st_q, st_d;
  logic [WAY_W-1:0]  way_q, way_d;
  logic [OFF_W-1:0]  beat_q, beat_d;
  logic              op_we_q, op_we_d, op_hit_q, op_hit_d;
  logic [ADDR_W-1:0] op_addr_q, op_addr_d;
  logic [DATA_W-1:0] op_wdata_q, op_wdata_d;
  logic              rsp_v_q, rsp_v_d, rsp_h_q, rsp_h_d;
  logic [DATA_W-1:0] rsp_d_q, rsp_d_d;

  // datapath controls
  logic              lk_hit;
  logic [WAY_W-1:0]  lk_way, lk_victim, lru_way, touch_way, wr_way;
  logic              touch, inc_hit, inc_miss, wr_en, alloc_en, dirty_set, inval_all;
  logic [OFF_W-1:0]  wr_off;
  logic [DATA_W-1:0] wr_byte;
  logic              victim_wb, flush_wb;

  assoc2_lookup #(.TAG_W(TAG_W), .LINES(LINES), .WAY_W(WAY_W)) u_lookup (
    .valid(valid_q), .tags(tag_q), .probe(req_addr[ADDR_W-1:OFF_W]),
    .lru_way(lru_way), .hit(lk_hit), .hit_way(lk_way), .victim_way(lk_victim)
  );

  assoc2_lru #(.WAY_W(WAY_W)) u_lru (
    .clk(clk), .rst_n(rst_n), .touch(touch), .touch_way(touch_way), .lru_way(lru_way)
  );

  assoc2_counters #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc_hit(inc_hit), .inc_miss(inc_miss),
    .hit_count(hit_count), .miss_count(miss_count)
  );

  assign req_ready = (st_q == ST_IDLE) && !flush;
  assign victim_wb = WRITE_BACK && valid_q[lk_victim] && dirty_q[lk_victim];
  assign flush_wb  = WRITE_BACK && valid_q[way_q] && dirty_q[way_q];

  always_comb begin
    st_d       = st_q;
    way_d      = way_q;
    beat_d     = beat_q;
    op_we_d    = op_we_q;
    op_hit_d   = op_hit_q;
    op_addr_d  = op_addr_q;
    op_wdata_d = op_wdata_q;
    rsp_v_d    = 1'b0;
    rsp_h_d    = rsp_h_q;
    rsp_d_d    = rsp_d_q;
    touch      = 1'b0;
    touch_way  = way_q;
    inc_hit    = 1'b0;
    inc_miss   = 1'b0;
    wr_en      = 1'b0;
    wr_way     = way_q;
    wr_off     = op_addr_q[OFF_W-1:0];
    wr_byte    = op_wdata_q;
    alloc_en   = 1'b0;
    dirty_set  = 1'b0;
    inval_all  = 1'b0;
    mem_req    = 1'b0;
    mem_we     = 1'b0;
    mem_addr   = op_addr_q;
    mem_wdata  = op_wdata_q;
    unique case (st_q)
      ST_IDLE: begin
        if (flush) begin
          st_d   = ST_FLUSH;
          way_d  = '0;
          beat_d = '0;
        end else if (req_valid) begin
          op_we_d    = req_write;
          op_addr_d  = req_addr;
          op_wdata_d = req_wdata;
          op_hit_d   = lk_hit;
          if (lk_hit) begin
            inc_hit   = 1'b1;
            touch     = 1'b1;
            touch_way = lk_way;
            way_d     = lk_way;
            if (req_write) begin
              wr_en     = 1'b1;
              wr_way    = lk_way;
              wr_off    = req_addr[OFF_W-1:0];
              wr_byte   = req_wdata;
              dirty_set = WRITE_BACK;
              if (WRITE_BACK) begin
                rsp_v_d = 1'b1;
                rsp_h_d = 1'b1;
                rsp_d_d = req_wdata;
              end else begin
                st_d = ST_WTHRU;
              end
            end else begin
              rsp_v_d = 1'b1;
              rsp_h_d = 1'b1;
              rsp_d_d = data_q[lk_way][req_addr[OFF_W-1:0]];
            end
          end else begin
            inc_miss = 1'b1;
            way_d    = lk_victim;
            beat_d   = '0;
            st_d     = victim_wb ? ST_EVICT : ST_FILL;
          end
        end
      end
      ST_EVICT: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = {tag_q[way_q], beat_q};
        mem_wdata = data_q[way_q][beat_q];
        if (mem_ack) begin
          if (beat_q == LAST_BEAT) begin
            beat_d = '0;
            st_d   = ST_FILL;
          end else begin
            beat_d = beat_q + 1'b1;
          end
        end
      end
      ST_FILL: begin
        mem_req  = 1'b1;
        mem_addr = {op_addr_q[ADDR_W-1:OFF_W], beat_q};
        if (mem_ack) begin
          wr_en   = 1'b1;
          wr_off  = beat_q;
          wr_byte = mem_rdata;
          if (beat_q == LAST_BEAT) begin
            alloc_en = 1'b1;
            st_d     = ST_APPLY;
          end else begin
            beat_d = beat_q + 1'b1;
          end
        end
      end
      ST_APPLY: begin
        touch = 1'b1;
        if (op_we_q) begin
          wr_en     = 1'b1;
          dirty_set = WRITE_BACK;
          if (WRITE_BACK) begin
            rsp_v_d = 1'b1;
            rsp_h_d = 1'b0;
            rsp_d_d = op_wdata_q;
            st_d    = ST_IDLE;
          end else begin
            st_d = ST_WTHRU;
          end
        end else begin
          rsp_v_d = 1'b1;
          rsp_h_d = 1'b0;
          rsp_d_d = data_q[way_q][op_addr_q[OFF_W-1:0]];
          st_d    = ST_IDLE;
        end
      end
      ST_WTHRU: begin
        mem_req = 1'b1;
        mem_we  = 1'b1;
        if (mem_ack) begin
          rsp_v_d = 1'b1;
          rsp_h_d = op_hit_q;
          rsp_d_d = op_wdata_q;
          st_d    = ST_IDLE;
        end
      end
      ST_FLUSH: begin
        if (flush_wb) begin
          mem_req   = 1'b1;
          mem_we    = 1'b1;
          mem_addr  = {tag_q[way_q], beat_q};
          mem_wdata = data_q[way_q][beat_q];
        end
        if (!flush_wb || (mem_ack && beat_q == LAST_BEAT)) begin
          beat_d = '0;
          if (way_q == LAST_WAY) begin
            inval_all = 1'b1;
            st_d      = ST_IDLE;
          end else begin
            way_d = way_q + 1'b1;
          end
        end else if (mem_ack) begin
          beat_d = beat_q + 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      way_q      <= '0;
      beat_q     <= '0;
      op_we_q    <= 1'b0;
      op_hit_q   <= 1'b0;
      op_addr_q  <= '0;
      op_wdata_q <= '0;
      rsp_v_q    <= 1'b0;
      rsp_h_q    <= 1'b0;
      rsp_d_q    <= '0;
    end else begin
      st_q       <= st_d;
      way_q      <= way_d;
      beat_q     <= beat_d;
      op_we_q    <= op_we_d;
      op_hit_q   <= op_hit_d;
      op_addr_q  <= op_addr_d;
      op_wdata_q <= op_wdata_d;
      rsp_v_q    <= rsp_v_d;
      rsp_h_q    <= rsp_h_d;
      rsp_d_q    <= rsp_d_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (inval_all) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      if (alloc_en) begin
        valid_q[way_q] <= 1'b1;
        dirty_q[way_q] <= 1'b0;
      end
      if (dirty_set) dirty_q[wr_way] <= 1'b1;
    end
  end

  // tag and data arrays carry no reset; valid_q guards them
  always_ff @(posedge clk) begin
    if (alloc_en) tag_q[way_q] <= op_addr_q[ADDR_W-1:OFF_W];
    if (wr_en)    data_q[wr_way][wr_off] <= wr_byte;
  end

  assign resp_valid = rsp_v_q;
  assign resp_hit   = rsp_h_q;
  assign resp_rdata = rsp_d_q;
endmodule

// File: rtl/assoc2_cache_chk.sv
module assoc2_cache_chk #(
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 8,
  parameter int CNT_W      = 8,
  parameter bit WRITE_BACK = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_ack,
  input logic [CNT_W-1:0]  hit_count,
  input logic [CNT_W-1:0]  miss_count
);
  p_ready_vs_mem_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req);

  p_mem_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));

  p_hit_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_count != $past(hit_count)) |-> (hit_count == CNT_W'($past(hit_count) + 1'b1)));

  p_miss_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_count != $past(miss_count)) |-> (miss_count == CNT_W'($past(miss_count) + 1'b1)));

  p_miss_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_count != $past(miss_count)) |-> !req_ready);

  if (!WRITE_BACK) begin : g_wt
    p_single_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && mem_ack) |=> !mem_req);
  end
endmodule

bind assoc2_cache assoc2_cache_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .WRITE_BACK(WRITE_BACK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .mem_req(mem_req),
  .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
  .hit_count(hit_count), .miss_count(miss_count)
);

// File: tb/assoc2_cache_bench.sv
module assoc2_cache_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // index 0: write-back instance, index 1: write-through instance
  logic          rv[2], rw[2], fl[2];
  logic [AW-1:0] ra[2];
  logic [DW-1:0] rwd[2];
  logic          rdy[2], resv[2], resh[2];
  logic [DW-1:0] resd[2];
  logic          mreq[2], mwe[2], mack[2];
  logic [AW-1:0] maddr[2];
  logic [DW-1:0] mwd[2], mrd[2];
  logic [CW-1:0] hc[2], mc[2];

  assoc2_cache #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW), .WRITE_BACK(1'b1)) u_assoc2_cache (
    .clk(clk), .rst_n(rst_n), .req_valid(rv[0]), .req_write(rw[0]), .req_addr(ra[0]),
    .req_wdata(rwd[0]), .req_ready(rdy[0]), .resp_valid(resv[0]), .resp_hit(resh[0]),
    .resp_rdata(resd[0]), .flush(fl[0]), .mem_req(mreq[0]), .mem_we(mwe[0]),
    .mem_addr(maddr[0]), .mem_wdata(mwd[0]), .mem_ack(mack[0]), .mem_rdata(mrd[0]),
    .hit_count(hc[0]), .miss_count(mc[0])
  );

  assoc2_cache #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW), .WRITE_BACK(1'b0)) u_assoc2_cache_wt (
    .clk(clk), .rst_n(rst_n), .req_valid(rv[1]), .req_write(rw[1]), .req_addr(ra[1]),
    .req_wdata(rwd[1]), .req_ready(rdy[1]), .resp_valid(resv[1]), .resp_hit(resh[1]),
    .resp_rdata(resd[1]), .flush(fl[1]), .mem_req(mreq[1]), .mem_we(mwe[1]),
    .mem_addr(maddr[1]), .mem_wdata(mwd[1]), .mem_ack(mack[1]), .mem_rdata(mrd[1]),
    .hit_count(hc[1]), .miss_count(mc[1])
  );

  logic [DW-1:0] bm[2][16];
  logic [DW-1:0] refm[2][16];
  logic [AW-1:0] rd_log[2][2];
  int rd_cnt[2], wr_cnt[2];
  int total = 0, bad = 0;
  bit done = 1'b0;

  // backing memory: acks one negedge after seeing a request
  initial begin
    for (int m = 0; m < 2; m++) begin
      mack[m] = 1'b0; mrd[m] = '0; rd_cnt[m] = 0; wr_cnt[m] = 0;
      rd_log[m][0] = '0; rd_log[m][1] = '0;
    end
    forever begin
      @(negedge clk);
      for (int m = 0; m < 2; m++) begin
        if (mack[m]) begin
          mack[m] = 1'b0;
        end else if (rst_n && mreq[m]) begin
          mack[m] = 1'b1;
          if (mwe[m]) begin
            bm[m][maddr[m]] = mwd[m];
            wr_cnt[m]++;
          end else begin
            mrd[m] = bm[m][maddr[m]];
            rd_cnt[m]++;
            rd_log[m][0] = rd_log[m][1];
            rd_log[m][1] = maddr[m];
          end
        end
      end
    end
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic access(input int m, input bit we, input int a, input int d,
                        input bit exp_hit, input string rq);
    int cyc;
    bit ready_seen;
    logic [DW-1:0] exp_d;
    @(negedge clk);
    while (!rdy[m]) @(negedge clk);
    rv[m] = 1'b1; rw[m] = we; ra[m] = AW'(a); rwd[m] = DW'(d);
    @(negedge clk);
    rv[m] = 1'b0;
    cyc = 1;
    ready_seen = 1'b0;
    while (!resv[m] && cyc < 200) begin
      if (rdy[m]) ready_seen = 1'b1;
      @(negedge clk);
      cyc++;
    end
    if (we) refm[m][a] = DW'(d);
    exp_d = we ? DW'(d) : refm[m][a];
    chk(resv[m] == 1'b1, {rq, " resp_valid"}, int'(resv[m]), 1);
    chk(resh[m] == exp_hit, {rq, " resp_hit"}, int'(resh[m]), int'(exp_hit));
    chk(resd[m] == exp_d, "R1 load/store data", int'(resd[m]), int'(exp_d));
    if (exp_hit && !(we && m == 1)) chk(cyc == 1, "R3 hit latency", cyc, 1);
    if (!exp_hit) chk(!ready_seen, "R2 ready low during miss", int'(ready_seen), 0);
  endtask

  task automatic t_reset();
    for (int m = 0; m < 2; m++) begin
      chk(rdy[m] && !resv[m] && !mreq[m], "R11 idle outputs", int'(rdy[m]), 1);
      chk(hc[m] == 0 && mc[m] == 0, "R11 counters cleared", int'(hc[m]) + int'(mc[m]), 0);
    end
  endtask

  task automatic t_trace(input int m);
    int r0, w0, w;
    r0 = rd_cnt[m];
    w0 = wr_cnt[m];
    access(m, 0, 1, 0, 1'b0, "R4 load 1 miss");
    chk(rd_log[m][0] == 0 && rd_log[m][1] == 1, "R4 fill order blk0", int'(rd_log[m][0]), 0);
    access(m, 0, 7, 0, 1'b0, "R4 load 7 miss");
    chk(rd_log[m][0] == 6 && rd_log[m][1] == 7, "R4 fill order blk3", int'(rd_log[m][0]), 6);
    w = wr_cnt[m];
    access(m, 1, 0, 8'hA5, 1'b1, "R3 store 0 hit");
    chk(wr_cnt[m] - w == (m == 1 ? 1 : 0), "R7 R8 store hit writes", wr_cnt[m] - w, m == 1 ? 1 : 0);
    w = wr_cnt[m];
    access(m, 1, 5, 8'h3C, 1'b0, "R6 store 5 miss");
    chk(wr_cnt[m] - w == (m == 1 ? 1 : 0), "R8 clean victim dropped", wr_cnt[m] - w, m == 1 ? 1 : 0);
    w = wr_cnt[m];
    access(m, 0, 10, 0, 1'b0, "R5 load 10 miss");
    chk(wr_cnt[m] - w == (m == 0 ? 2 : 0), "R8 dirty victim written", wr_cnt[m] - w, m == 0 ? 2 : 0);
    chk(hc[m] == 1, "R10 hit count", int'(hc[m]), 1);
    chk(mc[m] == 4, "R10 miss count", int'(mc[m]), 4);
    chk(rd_cnt[m] - r0 == 8, "R10 bytes read", rd_cnt[m] - r0, 8);
    chk(wr_cnt[m] - w0 == 2, "R10 bytes written", wr_cnt[m] - w0, 2);
    // line holding block 2 is most recent before the load of 10, so it survives
    access(m, 0, 4, 0, 1'b1, "R5 recency kept block 2");
    access(m, 0, 0, 0, 1'b0, "R5 block 0 was evicted");
  endtask

  task automatic t_flush(input int m, input int w_trace);
    int w, diffs;
    w = wr_cnt[m];
    @(negedge clk);
    while (!rdy[m]) @(negedge clk);
    fl[m] = 1'b1;
    #1;
    chk(rdy[m] == 1'b0, "R2 flush blocks ready", int'(rdy[m]), 0);
    @(negedge clk);
    fl[m] = 1'b0;
    while (!rdy[m]) @(negedge clk);
    chk(wr_cnt[m] - w == (m == 0 ? 2 : 0), "R9 flush writes", wr_cnt[m] - w, m == 0 ? 2 : 0);
    chk(wr_cnt[m] - w_trace == (m == 0 ? 4 : 2), "R10 total writes", wr_cnt[m] - w_trace, m == 0 ? 4 : 2);
    diffs = 0;
    for (int i = 0; i < 16; i++) if (bm[m][i] != refm[m][i]) diffs++;
    chk(diffs == 0, m == 0 ? "R8 memory image" : "R7 memory image", diffs, 0);
    access(m, 0, 4, 0, 1'b0, "R9 miss after flush");
  endtask

  task automatic t_alloc(input int m);
    access(m, 1, 9, 8'h5E, 1'b0, "R6 store miss allocates");
    access(m, 0, 9, 0, 1'b1, "R6 stored byte hits");
    access(m, 0, 8, 0, 1'b1, "R6 neighbour byte fetched");
  endtask

  initial begin
    int w_start;
    rst_n = 1'b0;
    for (int m = 0; m < 2; m++) begin
      rv[m] = 1'b0; rw[m] = 1'b0; ra[m] = '0; rwd[m] = '0; fl[m] = 1'b0;
      for (int i = 0; i < 16; i++) begin
        bm[m][i]   = DW'(8'h20 + i * 3);
        refm[m][i] = DW'(8'h20 + i * 3);
      end
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    for (int m = 0; m < 2; m++) begin
      w_start = wr_cnt[m];
      t_trace(m);
      t_flush(m, w_start);
      t_alloc(m);
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R2 watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule